// File: doc/BRIEF.md
# External Data Memory Address Router

This block sits between a CPU core and the 64 KB external data space. Each 16-bit read or write request is sent either to a 4 KB on-chip RAM or to an off-chip memory bus. A two-bit map mode selects where requests go. All requests can go to the on-chip RAM, all can go off-chip, or the space can be split at the 4 KB boundary.

Off-chip accesses use one of two bus forms, chosen by a single configuration bit. In multiplexed form, the low address byte first travels on the shared data lines during a one-cycle latch pulse. In non-multiplexed form, separate low-address lines carry it and there is no latch phase. Either way, the read or write strobe is held low for a fixed number of cycles. Ready is raised after the strobe is released.

The CPU holds its request valid until it sees ready. The router samples the map mode and the bus form when it accepts a request and holds them for that whole access.

Top module: `xdata_router`

## Requirements
- R1: While reset is asserted, req_ready, ram_en, ext_ale and ext_data_oe are 0, and ext_rd_n and ext_wr_n are 1.
- R2: With cfg_map = 0 (local only), every request goes to the on-chip RAM with ram_addr = req_addr[11:0], so the address wraps modulo 4 KB. No off-chip strobe, latch pulse or data drive occurs.
- R3: With cfg_map = 1 (off-chip only), every request goes to the off-chip bus and ram_en stays 0.
- R4: With cfg_map = 2 or 3 (split), addresses below 0x1000 go to the on-chip RAM and addresses from 0x1000 upward go off-chip.
- R5: With cfg_mux = 1, an off-chip access starts with exactly one cycle in which ext_ale = 1, ext_data_out = address[7:0] and ext_data_oe = 1, with both strobes high. The strobe phase begins in the next cycle, and ext_addr_lo stays 0.
- R6: With cfg_mux = 0, there is no latch pulse. The strobe starts in the cycle after acceptance, and ext_addr_lo = address[7:0] during the strobe. In both bus forms, ext_addr_hi = address[15:8] during the strobe.
- R7: One off-chip strobe stays low for exactly STROBE_CYCLES consecutive cycles. req_ready rises in the cycle right after the strobe is released. For a read, req_rdata equals the ext_data_in value seen in the last strobe cycle.
- R8: During an off-chip write, ext_wr_n is low, ext_rd_n is high, ext_data_oe = 1 and ext_data_out = write data. During a read, ext_rd_n is low, ext_wr_n is high and ext_data_oe = 0.
- R9: An on-chip access drives ram_en, ram_we, ram_addr and ram_wdata in its acceptance cycle. req_ready rises in the next cycle, and for a read, req_rdata is the RAM's read data.
- R10: Changes to cfg_map or cfg_mux after a request has been accepted do not alter that access's route, phases or timing.
- R11: req_ready is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_map | input | 2 | Map mode: 0 local only, 1 off-chip only, 2/3 split at 4 KB |
| cfg_mux | input | 1 | 1 selects the multiplexed off-chip bus form |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | Request byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read data, valid with req_ready |
| ram_en | output | 1 | On-chip RAM access enable |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | 12 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data, one cycle after ram_en |
| ext_addr_hi | output | 8 | Off-chip high address byte |
| ext_addr_lo | output | 8 | Off-chip low address byte (non-multiplexed form) |
| ext_data_out | output | 8 | Off-chip data/address driven value |
| ext_data_oe | output | 1 | Off-chip data output enable |
| ext_data_in | input | 8 | Off-chip data lines as read |
| ext_ale | output | 1 | Address latch pulse (multiplexed form) |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |

## Verification
Directed accesses are placed at the split boundary, 0x0FFF against 0x1000. Map mode 3 is also tried, which must act as split. These accesses separate a correct boundary compare from an off-by-one compare or a missing alias. A write at an address above 4 KB in local-only mode, followed by a read at the wrapped low address, shows that the RAM address truncates and does not saturate or go off-chip. Random mixes of mode, bus form, direction and address compare each access's phase sequence against a bench model: the latch cycle, the strobe length, the field values and the ready timing. Some accesses flip the configuration mid-access, which exposes any use of live configuration in place of the captured value.

// File: rtl/xdr_pkg.sv
package xdr_pkg;

    typedef enum logic [1:0] {
        MAP_LOCAL    = 2'd0,
        MAP_EXTERNAL = 2'd1,
        MAP_SPLIT    = 2'd2,
        MAP_SPLIT_B  = 2'd3
    } map_mode_e;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_ADDR   = 2'd1,
        BUS_STROBE = 2'd2,
        BUS_DONE   = 2'd3
    } bus_state_e;

    typedef enum logic [1:0] {
        TOP_IDLE     = 2'd0,
        TOP_LOCAL    = 2'd1,
        TOP_EXTERNAL = 2'd2
    } top_state_e;

endpackage

// File: rtl/xdr_route.sv
module xdr_route
    import xdr_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LOCAL_AW = 12
) (
    input  map_mode_e           mode,
    input  logic [ADDR_W-1:0]   addr,
    output logic                to_local
);

    logic below_local;

    // Address lies inside the on-chip window when all upper bits are zero.
    assign below_local = (addr[ADDR_W-1:LOCAL_AW] == '0);

    always_comb begin
        case (mode)
            MAP_LOCAL:    to_local = 1'b1;
            MAP_EXTERNAL: to_local = 1'b0;
            default:      to_local = below_local;
        endcase
    end

endmodule

// File: rtl/xdr_bus_seq.sv
module xdr_bus_seq
    import xdr_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int STROBE_CYCLES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     start_write,
    input  logic                     start_mux,
    input  logic [ADDR_W-1:0]        start_addr,
    input  logic [DATA_W-1:0]        start_wdata,
    output logic                     done,
    output logic                     busy,
    output logic [DATA_W-1:0]        rdata,
    output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
    output logic [DATA_W-1:0]        ext_addr_lo,
    output logic [DATA_W-1:0]        ext_data_out,
    output logic                     ext_data_oe,
    input  logic [DATA_W-1:0]        ext_data_in,
    output logic                     ext_ale,
    output logic                     ext_rd_n,
    output logic                     ext_wr_n
);

    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int CNT_W = $clog2(STROBE_CYCLES + 1);

    typedef struct packed {
        bus_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                write;
        logic                mux;
        logic [DATA_W-1:0]   rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            BUS_IDLE: begin
                if (start) begin
                    seq_d.addr  = start_addr;
                    seq_d.wdata = start_wdata;
                    seq_d.write = start_write;
                    seq_d.mux   = start_mux;
                    seq_d.cnt   = CNT_W'(STROBE_CYCLES - 1);
                    seq_d.state = start_mux ? BUS_ADDR : BUS_STROBE;
                end
            end
            BUS_ADDR: seq_d.state = BUS_STROBE;
            BUS_STROBE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = BUS_DONE;
                    if (!seq_q.write) begin
                        seq_d.rdata = ext_data_in;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.state = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    logic in_addr, in_strobe, active;

    assign in_addr   = (seq_q.state == BUS_ADDR);
    assign in_strobe = (seq_q.state == BUS_STROBE);
    assign active    = (seq_q.state != BUS_IDLE);

    assign done         = (seq_q.state == BUS_DONE);
    assign busy         = active;
    assign rdata        = seq_q.rdata;
    assign ext_addr_hi  = active ? seq_q.addr[ADDR_W-1:DATA_W] : '0;
    assign ext_addr_lo  = (active && !seq_q.mux) ? seq_q.addr[DATA_W-1:0] : '0;
    assign ext_ale      = in_addr;
    assign ext_data_oe  = in_addr || (in_strobe && seq_q.write);
    assign ext_data_out = in_addr ? seq_q.addr[DATA_W-1:0] :
                          ((in_strobe && seq_q.write) ? seq_q.wdata : '0);
    assign ext_rd_n     = !(in_strobe && !seq_q.write);
    assign ext_wr_n     = !(in_strobe && seq_q.write);

    // Run-length counter of strobe-low cycles, used only by the checks below.
    logic               strobe_low;
    logic [CNT_W:0]     run_q;

    assign strobe_low = !ext_rd_n || !ext_wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (strobe_low) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R5: the latch pulse lasts one cycle and is followed by a strobe.
    a_r5_latch_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ale |=> (!ext_ale && strobe_low));

    // R7: a strobe run that ends has lasted exactly STROBE_CYCLES.
    a_r7_strobe_length: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q != '0 && !strobe_low) |-> (run_q == (CNT_W+1)'(STROBE_CYCLES)));

    // R10: the high address byte holds through an access.
    a_r10_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !done) |-> $stable(ext_addr_hi));

    // R8: read and write strobes never overlap.
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ext_rd_n, !ext_wr_n}));

endmodule

// File: rtl/xdata_router.sv
module xdata_router
    import xdr_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int LOCAL_AW      = 12,
    parameter int STROBE_CYCLES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_map,
    input  logic                     cfg_mux,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic [DATA_W-1:0]        req_rdata,
    output logic                     ram_en,
    output logic                     ram_we,
    output logic [LOCAL_AW-1:0]      ram_addr,
    output logic [DATA_W-1:0]        ram_wdata,
    input  logic [DATA_W-1:0]        ram_rdata,
    output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
    output logic [DATA_W-1:0]        ext_addr_lo,
    output logic [DATA_W-1:0]        ext_data_out,
    output logic                     ext_data_oe,
    input  logic [DATA_W-1:0]        ext_data_in,
    output logic                     ext_ale,
    output logic                     ext_rd_n,
    output logic                     ext_wr_n
);

    typedef struct packed {
        top_state_e state;
    } top_t;

    top_t top_d, top_q;

    logic              to_local;
    logic              seq_start;
    logic              seq_done;
    logic              seq_busy;
    logic [DATA_W-1:0] seq_rdata;

    xdr_route #(
        .ADDR_W   (ADDR_W),
        .LOCAL_AW (LOCAL_AW)
    ) u_route (
        .mode     (map_mode_e'(cfg_map)),
        .addr     (req_addr),
        .to_local (to_local)
    );

    xdr_bus_seq #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .STROBE_CYCLES (STROBE_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (seq_start),
        .start_write  (req_write),
        .start_mux    (cfg_mux),
        .start_addr   (req_addr),
        .start_wdata  (req_wdata),
        .done         (seq_done),
        .busy         (seq_busy),
        .rdata        (seq_rdata),
        .ext_addr_hi  (ext_addr_hi),
        .ext_addr_lo  (ext_addr_lo),
        .ext_data_out (ext_data_out),
        .ext_data_oe  (ext_data_oe),
        .ext_data_in  (ext_data_in),
        .ext_ale      (ext_ale),
        .ext_rd_n     (ext_rd_n),
        .ext_wr_n     (ext_wr_n)
    );

    always_comb begin
        top_d     = top_q;
        seq_start = 1'b0;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = req_addr[LOCAL_AW-1:0];
        ram_wdata = req_wdata;
        req_ready = 1'b0;
        req_rdata = '0;
        case (top_q.state)
            TOP_IDLE: begin
                if (req_valid) begin
                    if (to_local) begin
                        ram_en      = 1'b1;
                        ram_we      = req_write;
                        top_d.state = TOP_LOCAL;
                    end else begin
                        seq_start   = 1'b1;
                        top_d.state = TOP_EXTERNAL;
                    end
                end
            end
            TOP_LOCAL: begin
                req_ready   = 1'b1;
                req_rdata   = ram_rdata;
                top_d.state = TOP_IDLE;
            end
            TOP_EXTERNAL: begin
                if (seq_done) begin
                    req_ready   = 1'b1;
                    req_rdata   = seq_rdata;
                    top_d.state = TOP_IDLE;
                end
            end
            default: top_d.state = TOP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    // R11: completion is a single-cycle pulse.
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R9: an on-chip access completes in the next cycle.
    a_r9_local_next: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |=> (req_ready && !seq_busy));

    // R3: off-chip-only mode never touches the on-chip RAM.
    a_r3_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.state == TOP_IDLE && req_valid && cfg_map == 2'd1) |-> (!ram_en && seq_start));

    // R2: local-only mode keeps the off-chip bus quiet for the access.
    a_r2_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.state == TOP_IDLE && req_valid && cfg_map == 2'd0) |=> (!seq_busy && ext_rd_n && ext_wr_n));

endmodule

// File: tb/xdata_router_tb.sv
module xdata_router_tb;

    localparam int STRB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_map = 2'd0;
    logic        cfg_mux = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  req_rdata;
    logic        ram_en, ram_we;
    logic [11:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [7:0]  ext_addr_hi, ext_addr_lo, ext_data_out, ext_data_in;
    logic        ext_data_oe, ext_ale, ext_rd_n, ext_wr_n;
    logic [15:0] cur_addr = '0;

    int errors = 0;
    int checks = 0;

    logic [7:0] ram_model [4096];
    logic [7:0] exp_mem   [4096];

    always #4 clk = ~clk;

    xdata_router #(.STROBE_CYCLES(STRB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_map(cfg_map), .cfg_mux(cfg_mux),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .ext_addr_hi(ext_addr_hi), .ext_addr_lo(ext_addr_lo),
        .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
        .ext_data_in(ext_data_in), .ext_ale(ext_ale),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    function automatic logic [7:0] ext_pattern(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic bit exp_local(input logic [1:0] m, input logic [15:0] a);
        if (m == 2'd0) return 1'b1;
        if (m == 2'd1) return 1'b0;
        return a < 16'h1000;
    endfunction

    assign ext_data_in = ext_pattern(cur_addr);

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) ram_model[ram_addr] <= ram_wdata;
            ram_rdata <= ram_model[ram_addr];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Observation state for one access.
    int ram_seen, ram_idx, ale_cnt, ale_idx, strb_cnt, strb_first, ready_idx;
    bit ram_ok, ale_ok, strb_ok;
    logic [7:0] rd_seen;

    task automatic observe(input int idx, input bit wr, input bit mx,
                           input logic [15:0] a, input logic [7:0] wd);
        if (ram_en) begin
            ram_seen++;
            ram_idx = idx;
            if (ram_addr != a[11:0] || ram_we != wr || (wr && ram_wdata != wd)) ram_ok = 0;
        end
        if (ext_ale) begin
            ale_cnt++;
            ale_idx = idx;
            if (ext_data_out != a[7:0] || !ext_data_oe || !ext_rd_n || !ext_wr_n) ale_ok = 0;
        end
        if (!ext_rd_n || !ext_wr_n) begin
            if (strb_cnt == 0) strb_first = idx;
            strb_cnt++;
            if (ext_addr_hi != a[15:8]) strb_ok = 0;
            if (ext_addr_lo != (mx ? 8'h00 : a[7:0])) strb_ok = 0;
            if (wr) begin
                if (ext_wr_n || !ext_rd_n || !ext_data_oe || ext_data_out != wd) strb_ok = 0;
            end else begin
                if (ext_rd_n || !ext_wr_n || ext_data_oe) strb_ok = 0;
            end
        end
        if (req_ready && ready_idx < 0) begin
            ready_idx = idx;
            rd_seen = req_rdata;
        end
    endtask

    task automatic access(input logic [1:0] m, input bit mx, input bit wr,
                          input logic [15:0] a, input logic [7:0] wd, input bit glitch);
        bit    loc;
        string rt;
        int    first;
        loc = exp_local(m, a);
        rt  = (m == 2'd0) ? "R2" : ((m == 2'd1) ? "R3" : "R4");
        ram_seen = 0; ram_idx = -1; ale_cnt = 0; ale_idx = -1;
        strb_cnt = 0; strb_first = -1; ready_idx = -1;
        ram_ok = 1; ale_ok = 1; strb_ok = 1; rd_seen = '0;
        cfg_map = m; cfg_mux = mx; req_write = wr; req_addr = a; req_wdata = wd;
        cur_addr = a; req_valid = 1'b1;
        #1;
        observe(0, wr, mx, a, wd);
        for (int idx = 1; idx < 40; idx++) begin
            @(negedge clk);
            if (glitch && idx == 1) begin
                cfg_map = ~m;
                cfg_mux = ~mx;
            end
            #1;
            observe(idx, wr, mx, a, wd);
            if (ready_idx >= 0) break;
        end
        req_valid = 1'b0;
        cfg_map = m; cfg_mux = mx;
        @(negedge clk); #1;
        chk(!req_ready, "R11 ready single pulse", int'(req_ready), 0);
        chk(ready_idx >= 0, "R7/R9 access completed", ready_idx, 1);
        chk(ram_seen == (loc ? 1 : 0), rt, ram_seen, loc ? 1 : 0);
        if (loc) begin
            chk(ram_idx == 0 && ram_ok, "R9 RAM drive in accept cycle", ram_idx, 0);
            chk(strb_cnt == 0 && ale_cnt == 0, "R2 off-chip quiet", strb_cnt + ale_cnt, 0);
            chk(ready_idx == 1, glitch ? "R10 local timing" : "R9 ready next cycle", ready_idx, 1);
            if (!wr) chk(rd_seen == exp_mem[a[11:0]], "R9 local read data", rd_seen, exp_mem[a[11:0]]);
            else exp_mem[a[11:0]] = wd;
        end else begin
            first = mx ? 2 : 1;
            if (mx) chk(ale_cnt == 1 && ale_idx == 1 && ale_ok, "R5 latch phase", ale_cnt, 1);
            else    chk(ale_cnt == 0, "R6 no latch phase", ale_cnt, 0);
            chk(strb_ok, wr ? "R8 write strobe fields" : "R8 read strobe fields", 0, 1);
            chk(strb_cnt == STRB && strb_first == first, glitch ? "R10 strobe window" : "R7 strobe length",
                strb_cnt, STRB);
            chk(ready_idx == first + STRB, "R7 ready after strobe", ready_idx, first + STRB);
            if (!wr) chk(rd_seen == ext_pattern(a), "R7 read data", rd_seen, ext_pattern(a));
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unused_seed;
        for (int i = 0; i < 4096; i++) begin
            ram_model[i] = '0;
            exp_mem[i]   = '0;
        end
        unused_seed = int'($urandom(32'h1F2E));
        repeat (3) @(negedge clk);
        chk(!req_ready && !ram_en && !ext_ale && !ext_data_oe && ext_rd_n && ext_wr_n,
            "R1 reset state", {req_ready, ram_en, ext_ale, ext_data_oe, ext_rd_n, ext_wr_n}, 6'b000011);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners.
        access(2'd0, 0, 1, 16'hF123, 8'hAB, 0);   // R2 wrap write
        access(2'd2, 0, 0, 16'h0123, 8'h00, 0);   // R2 wrap read back in split
        access(2'd2, 0, 1, 16'h0FFF, 8'h3C, 0);   // R4 last local
        access(2'd2, 0, 0, 16'h0FFF, 8'h00, 0);
        access(2'd2, 0, 0, 16'h1000, 8'h00, 0);   // R4 first off-chip
        access(2'd3, 1, 0, 16'h0FFF, 8'h00, 0);   // R4 alias mode local
        access(2'd3, 1, 1, 16'h1000, 8'h77, 0);   // R4 alias mode off-chip
        access(2'd1, 1, 1, 16'h0004, 8'hC5, 0);   // R3 low addr off-chip, R5
        access(2'd1, 0, 0, 16'hBEEF, 8'h00, 0);   // R6
        access(2'd1, 1, 0, 16'h1234, 8'h00, 1);   // R10 mux flip
        access(2'd1, 0, 1, 16'h8001, 8'h99, 1);   // R10 nonmux flip
        access(2'd0, 0, 0, 16'h0FFF, 8'h00, 1);   // R10 local flip

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if ($urandom % 2) a = {4'h0, a[11:0]};
            access(2'($urandom), 1'($urandom), 1'($urandom), a, 8'($urandom), ($urandom % 8) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule